// File: doc/BRIEF.md
# Eight-Operation Byte ALU

This block is a purely combinational arithmetic logic unit for byte-wide data. It takes two operands, a single carry input and a three-bit operation code. It returns a result, a carry output and a signed overflow flag. Four codes select bitwise logic. The other four pass through one shared ripple-carry adder, and each of those folds the external carry input into its sum. A caller can therefore chain bytes, or turn the inverted-operand addition into a true subtraction, by setting the carry.

The logic results and the single adder sum feed a result selector indexed by the operation code. Code bit 2 is the most significant select bit. The flags come from the same adder. They are forced to zero whenever a logic code is selected, so a caller can read them without decoding the code again. The block has no clock, no storage and no latch, and every code value produces a defined output.

Top module: `alu8_core`

## Requirements
- R1: Code 3'b000 gives the bitwise OR of A and B.
- R2: Code 3'b001 gives the bitwise inverse of A; the value of B has no effect on any output.
- R3: Code 3'b010 gives A + ~B + carry-in modulo 256, so carry-in 1 yields A - B.
- R4: Code 3'b011 gives A + B + carry-in modulo 256.
- R5: Code 3'b100 gives the bitwise XOR of A and B.
- R6: Code 3'b101 gives the bitwise AND of A and B.
- R7: Code 3'b110 gives A + 8'hFF + carry-in modulo 256: A - 1 with carry-in 0, A unchanged with carry-in 1.
- R8: Code 3'b111 gives A + carry-in modulo 256; the value of B has no effect on any output.
- R9: For codes 2, 3, 6 and 7, carry-out is bit 8 of the 9-bit sum of A, the second adder operand (~B, B, 8'hFF or 8'h00 respectively) and carry-in. For codes 0, 1, 4 and 5, carry-out is 0.
- R10: For the adder codes, overflow is 1 exactly when A and the second adder operand share a sign bit (bit 7) and the result's bit 7 differs from it. For the logic codes, overflow is 0.
- R11: The outputs depend only on the present inputs, with no clock, and every code drives fully defined outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | 8 | First operand |
| opd_b | input | 8 | Second operand |
| carry_in | input | 1 | Carry folded into every adder operation |
| op_sel | input | 3 | Operation code, bit 2 most significant |
| result | output | 8 | Selected result |
| carry_out | output | 1 | Adder carry for adder codes, else 0 |
| ovf | output | 1 | Signed overflow for adder codes, else 0 |

## Verification
The assertions are immediate checks evaluated whenever the inputs change. They assume that all inputs are driven to known values, and they skip evaluation while any input is unknown. The stimulus changes inputs only half a clock period before the scoreboard samples, so the outputs have settled before they are compared. Corner operands (0x00, 0x7F, 0x80, 0xFF, equal operands) are applied under every code with both carry values. Random operands follow, and some of them repeat A with a new B so that the codes which ignore B are exercised.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [2:0] {
        OP_OR    = 3'd0,
        OP_INV_A = 3'd1,
        OP_SUB_B = 3'd2,
        OP_ADD   = 3'd3,
        OP_XOR   = 3'd4,
        OP_AND   = 3'd5,
        OP_DEC   = 3'd6,
        OP_INC   = 3'd7
    } alu_op_e;

    localparam int unsigned OP_COUNT = 8;
    localparam int unsigned OP_BITS  = 3;

    // Adder codes all have bit 1 set; logic codes all have it clear.
    function automatic logic op_uses_adder(input logic [OP_BITS-1:0] op);
        return op[1];
    endfunction

endpackage

// File: rtl/alu8_logic_unit.sv
module alu8_logic_unit #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] or_o,
    output logic [WIDTH-1:0] inv_o,
    output logic [WIDTH-1:0] xor_o,
    output logic [WIDTH-1:0] and_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign or_o[i]  = a_i[i] | b_i[i];
        assign inv_o[i] = ~a_i[i];
        assign xor_o[i] = a_i[i] ^ b_i[i];
        assign and_o[i] = a_i[i] & b_i[i];
    end

endmodule

// File: rtl/alu8_ripple_adder.sv
module alu8_ripple_adder #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic             c_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             c_o,
    output logic             v_o
);

    logic [WIDTH:0] chain;

    assign chain[0] = c_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_fa
        logic half;
        assign half        = x_i[i] ^ y_i[i];
        assign sum_o[i]    = half ^ chain[i];
        assign chain[i+1]  = (x_i[i] & y_i[i]) | (half & chain[i]);
    end

    assign c_o = chain[WIDTH];
    // Carry into and out of the sign position disagree on signed overflow.
    assign v_o = chain[WIDTH] ^ chain[WIDTH-1];

endmodule

// File: rtl/alu8_arith_unit.sv
module alu8_arith_unit
    import alu8_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0]   a_i,
    input  logic [WIDTH-1:0]   b_i,
    input  logic               c_i,
    input  logic [OP_BITS-1:0] op_i,
    output logic [WIDTH-1:0]   sum_o,
    output logic               c_o,
    output logic               v_o
);

    logic [WIDTH-1:0] y_sel;

    // Second adder operand chosen by the code; logic codes reuse B.
    always_comb begin
        unique case (alu_op_e'(op_i))
            OP_SUB_B: y_sel = ~b_i;
            OP_ADD:   y_sel = b_i;
            OP_DEC:   y_sel = {WIDTH{1'b1}};
            OP_INC:   y_sel = '0;
            default:  y_sel = b_i;
        endcase
    end

    alu8_ripple_adder #(.WIDTH(WIDTH)) u_adder (
        .x_i   (a_i),
        .y_i   (y_sel),
        .c_i   (c_i),
        .sum_o (sum_o),
        .c_o   (c_o),
        .v_o   (v_o)
    );

endmodule

// File: rtl/alu8_result_mux.sv
module alu8_result_mux #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned N_IN  = 8,
    localparam int unsigned SEL_W = $clog2(N_IN)
) (
    input  logic [N_IN-1:0][WIDTH-1:0] din_i,
    input  logic [SEL_W-1:0]           sel_i,
    output logic [WIDTH-1:0]           dout_o
);

    always_comb begin
        dout_o = '0;
        for (int k = 0; k < N_IN; k++) begin
            if (sel_i == SEL_W'(k)) dout_o = din_i[k];
        end
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] opd_a,
    input  logic [WIDTH-1:0] opd_b,
    input  logic             carry_in,
    input  logic [2:0]       op_sel,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             ovf
);

    logic [WIDTH-1:0] or_v, inv_v, xor_v, and_v, sum_v;
    logic             add_c, add_v, adder_op;
    logic [OP_COUNT-1:0][WIDTH-1:0] cand;

    alu8_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .a_i   (opd_a),
        .b_i   (opd_b),
        .or_o  (or_v),
        .inv_o (inv_v),
        .xor_o (xor_v),
        .and_o (and_v)
    );

    alu8_arith_unit #(.WIDTH(WIDTH)) u_arith (
        .a_i   (opd_a),
        .b_i   (opd_b),
        .c_i   (carry_in),
        .op_i  (op_sel),
        .sum_o (sum_v),
        .c_o   (add_c),
        .v_o   (add_v)
    );

    always_comb begin
        cand[OP_OR]    = or_v;
        cand[OP_INV_A] = inv_v;
        cand[OP_SUB_B] = sum_v;
        cand[OP_ADD]   = sum_v;
        cand[OP_XOR]   = xor_v;
        cand[OP_AND]   = and_v;
        cand[OP_DEC]   = sum_v;
        cand[OP_INC]   = sum_v;
    end

    alu8_result_mux #(.WIDTH(WIDTH), .N_IN(OP_COUNT)) u_mux (
        .din_i  (cand),
        .sel_i  (op_sel),
        .dout_o (result)
    );

    assign adder_op  = op_uses_adder(op_sel);
    assign carry_out = adder_op & add_c;
    assign ovf       = adder_op & add_v;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic [WIDTH-1:0] opd_a,
    input logic [WIDTH-1:0] opd_b,
    input logic             carry_in,
    input logic [2:0]       op_sel,
    input logic [WIDTH-1:0] result,
    input logic             carry_out,
    input logic             ovf
);

    logic known;
    assign known = !$isunknown({opd_a, opd_b, carry_in, op_sel});

    always_comb begin
        if (known) begin
            if (op_sel == 3'd0 || op_sel == 3'd1 || op_sel == 3'd4 || op_sel == 3'd5)
                AST_LOGIC_FLAGS_CLEAR: assert (!carry_out && !ovf);            // R9
            if (op_sel == 3'd1)
                AST_INV_COMPLEMENTS: assert ((result ^ opd_a) == {WIDTH{1'b1}}); // R2
            if (op_sel == 3'd3)
                AST_ADD_SUM: assert ({carry_out, result} == ({1'b0, opd_a} + {1'b0, opd_b} + (WIDTH+1)'(carry_in))); // R4
            if (op_sel == 3'd2 && carry_in && opd_a == opd_b)
                AST_SUB_EQUAL_ZERO: assert (result == '0 && carry_out);          // R3
            if (op_sel == 3'd6 && carry_in)
                AST_DEC_PASS: assert (result == opd_a && carry_out);              // R7
            if (op_sel == 3'd7 && !carry_in)
                AST_INC_PASS: assert (result == opd_a && !carry_out && !ovf);     // R8
            if (op_sel == 3'd3 && opd_a[WIDTH-1] != opd_b[WIDTH-1])
                AST_NO_OVERFLOW: assert (!ovf);                                   // R10
            AST_OUT_DEFINED: assert (!$isunknown({result, carry_out, ovf}));      // R11
        end
    end

endmodule

bind alu8_core alu8_core_chk #(.WIDTH(WIDTH)) u_chk (
    .opd_a     (opd_a),
    .opd_b     (opd_b),
    .carry_in  (carry_in),
    .op_sel    (op_sel),
    .result    (result),
    .carry_out (carry_out),
    .ovf       (ovf)
);

// File: tb/tb_alu8_core.sv
module tb_alu8_core;

    localparam int W = 8;

    typedef struct {
        logic [2:0]   op;
        logic [W-1:0] a, b;
        logic         cin;
        logic [W-1:0] res;
        logic         co, ov;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a = '0, b = '0;
    logic         cin = 1'b0;
    logic [2:0]   op = 3'd0;
    logic [W-1:0] result;
    logic         carry_out, ovf;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;
    item_t q[$];

    always #5 clk = ~clk;

    alu8_core dut (
        .opd_a(a), .opd_b(b), .carry_in(cin), .op_sel(op),
        .result(result), .carry_out(carry_out), .ovf(ovf)
    );

    function automatic string res_tag(input logic [2:0] o);
        case (o)
            3'd0: return "R1";  3'd1: return "R2";
            3'd2: return "R3";  3'd3: return "R4";
            3'd4: return "R5";  3'd5: return "R6";
            3'd6: return "R7";  default: return "R8";
        endcase
    endfunction

    function automatic item_t model(input logic [2:0] o, input logic [W-1:0] x,
                                    input logic [W-1:0] y, input logic c);
        item_t it;
        logic [W-1:0] y2;
        logic [W:0]   s;
        it.op = o; it.a = x; it.b = y; it.cin = c;
        it.co = 1'b0; it.ov = 1'b0;
        case (o)
            3'd0: it.res = x | y;
            3'd1: it.res = ~x;
            3'd4: it.res = x ^ y;
            3'd5: it.res = x & y;
            default: begin
                y2 = (o == 3'd2) ? ~y : (o == 3'd3) ? y : (o == 3'd6) ? 8'hFF : 8'h00;
                s = {1'b0, x} + {1'b0, y2} + {8'd0, c};
                it.res = s[W-1:0];
                it.co  = s[W];
                it.ov  = (x[W-1] == y2[W-1]) && (s[W-1] != x[W-1]);
            end
        endcase
        return it;
    endfunction

    task automatic drive(input logic [2:0] o, input logic [W-1:0] x,
                         input logic [W-1:0] y, input logic c);
        @(negedge clk);
        op = o; a = x; b = y; cin = c;
        q.push_back(model(o, x, y, c));
    endtask

    // Monitor: sample half a period after each drive.
    always @(posedge clk) begin
        if (!rst && q.size() > 0) begin
            item_t e;
            e = q.pop_front();
            n_run++;
            if ($isunknown({result, carry_out, ovf})) begin
                n_fail++;
                $display("FAIL R11 op=%0d outputs unknown: got %b/%b/%b expected %h/%b/%b",
                         e.op, result, carry_out, ovf, e.res, e.co, e.ov);
            end else if (result !== e.res) begin
                n_fail++;
                $display("FAIL %s op=%0d a=%h b=%h cin=%b result got %h expected %h",
                         res_tag(e.op), e.op, e.a, e.b, e.cin, result, e.res);
            end else if (carry_out !== e.co) begin
                n_fail++;
                $display("FAIL R9 op=%0d a=%h b=%h cin=%b carry got %b expected %b",
                         e.op, e.a, e.b, e.cin, carry_out, e.co);
            end else if (ovf !== e.ov) begin
                n_fail++;
                $display("FAIL R10 op=%0d a=%h b=%h cin=%b ovf got %b expected %b",
                         e.op, e.a, e.b, e.cin, ovf, e.ov);
            end
        end
    end

    initial begin : watchdog
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [W-1:0] corner [6];
        logic [W-1:0] ra;
        corner[0] = 8'h00; corner[1] = 8'h7F; corner[2] = 8'h80;
        corner[3] = 8'hFF; corner[4] = 8'h01; corner[5] = 8'h55;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // Reset-state style check: all-zero inputs under code 0 (R1, R11).
        drive(3'd0, 8'h00, 8'h00, 1'b0);
        // R3: A - B with carry 1, equal operands and borrow case.
        drive(3'd2, 8'h42, 8'h42, 1'b1);
        drive(3'd2, 8'h10, 8'h20, 1'b1);
        // R10: signed overflow on add (7F+01) and subtract (80-01).
        drive(3'd3, 8'h7F, 8'h01, 1'b0);
        drive(3'd2, 8'h80, 8'h01, 1'b1);
        // R7: decrement of zero wraps, pass-through with carry 1.
        drive(3'd6, 8'h00, 8'h33, 1'b0);
        drive(3'd6, 8'h80, 8'h33, 1'b1);
        // R8: increment of FF carries out.
        drive(3'd7, 8'hFF, 8'h12, 1'b1);
        // Corner sweep over every code and carry value (R1-R8 each).
        for (int o = 0; o < 8; o++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    for (int c = 0; c < 2; c++)
                        drive(3'(o), corner[i], corner[j], 1'(c));
        // Random operands; same A with two different B values (R2, R8 ignore B).
        for (int n = 0; n < 600; n++) begin
            logic [2:0] ro;
            ra = 8'($urandom);
            ro = 3'($urandom);
            drive(ro, ra, 8'($urandom), 1'($urandom));
            drive(ro, ra, 8'($urandom), 1'($urandom));
        end
        while (q.size() > 0) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule